// File: doc/BRIEF.md
# Block Fetch and Refill Coordinator

This block is the fetch-side controller of a tiled processor that executes code in atomic blocks of up to 128 instructions. Each block is one header chunk plus one to four body chunks, and each chunk lives in its own instruction-cache tile. The controller alone holds the tag and valid state of the cached blocks; the tiles hold only data. When a block address is requested, the controller looks up its direct-mapped tag store. On a hit it starts dispatch at once. On a miss it broadcasts the refill address to every tile in one cycle. It then gathers each tile's refill-done report in a bitmask and starts dispatch only when every tile has reported.

Dispatch runs the participating tiles in parallel for a fixed number of beats. In each beat every enabled tile sends one group of instructions to its row of execution tiles. The header tile always takes part, and body tiles join in order up to the requested chunk count. While any request is in progress the controller is busy and ignores new requests, so a second miss can never overlap an outstanding refill.

Top module: `blk_fetch_ctrl`

## Requirements
- R1: After reset `busy`, `refill_valid` and `disp_en` are all low, and every tag line is invalid, so the first request to any address is a miss.
- R2: A request is accepted on a clock edge where `req_valid` is high and `busy` is low. On a hit, `busy` rises and dispatch starts in the very next cycle, with no refill broadcast.
- R3: On a miss, `refill_valid` is high for exactly one cycle, in the cycle right after acceptance, with `refill_addr` equal to the requested address. `refill_addr` holds its value while `busy` is high.
- R4: Dispatch stays held while any of the NUM_TILES tiles has not yet raised its bit of `refill_done` during the current refill. Bits may arrive in any order, one at a time or together. A repeated bit from the same tile counts only once, and the collected set is cleared when each new miss starts.
- R5: The cycle after the edge on which the last missing done bit is sampled, dispatch starts. The line is installed, so a later request to the same address hits.
- R6: Dispatch lasts exactly BEATS (8) consecutive cycles. `disp_beat` counts 0 to 7 and `disp_addr` equals the request address. In the cycle after beat 7 `disp_en` is zero and `busy` is low.
- R7: `disp_en` bit 0 is the header tile and is always set during dispatch. Bits 1 to n are set for a body chunk count n taken from `req_chunks`. A count of 0 is treated as 1, and a count above NUM_TILES-1 (4) is treated as 4. The enabled set is therefore always contiguous from bit 0.
- R8: A request presented while `busy` is high is ignored. It is not dispatched, it triggers no broadcast, and it installs nothing.
- R9: The tag store is direct-mapped. The line index is `req_addr[IDX_W-1:0]` (4 bits) and the tag is the remaining upper bits. A request with a matching index but a different tag misses, and its refill replaces the old line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Block fetch request |
| req_addr | input | ADDR_W (16) | Block address of the request |
| req_chunks | input | CHUNK_W (3) | Number of body chunks, clamped to 1..4 |
| busy | output | 1 | Request in progress; new requests are ignored |
| refill_valid | output | 1 | One-cycle refill broadcast to all tiles |
| refill_addr | output | ADDR_W (16) | Address being refilled |
| refill_done | input | NUM_TILES (5) | Per-tile refill completion strobes |
| disp_en | output | NUM_TILES (5) | Per-tile dispatch enables |
| disp_beat | output | BEAT_W (3) | Dispatch beat number |
| disp_addr | output | ADDR_W (16) | Address of the block being dispatched |

## Verification
The assertions check the following on every cycle:
- the controller is quiet when idle;
- the broadcast is a single-cycle pulse with a held address;
- dispatch never overlaps the broadcast;
- the enable set is contiguous and always includes the header tile;
- beats step by one from zero and stop after the last.

Only the bench scenarios can show the rest:
- hit versus miss decisions;
- that dispatch waits for the complete set of tile reports, including duplicate and out-of-order bits;
- replacement of a conflicting line;
- that a request made while busy leaves no trace in the tag store.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REFILL = 2'd1,
        ST_DISP   = 2'd2
    } fetch_state_t;

endpackage

// File: rtl/bfc_tag_store.sv
module bfc_tag_store #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr
);
    localparam int LINES = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic [LINES-1:0]            valid;
        logic [LINES-1:0][TAG_W-1:0] tag;
    } store_t;

    store_t s_d, s_q;

    logic [IDX_W-1:0] lk_idx, wr_idx;
    assign lk_idx = lk_addr[IDX_W-1:0];
    assign wr_idx = wr_addr[IDX_W-1:0];

    assign lk_hit = s_q.valid[lk_idx] && (s_q.tag[lk_idx] == lk_addr[ADDR_W-1:IDX_W]);

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.valid[wr_idx] = 1'b1;
            s_d.tag[wr_idx]   = wr_addr[ADDR_W-1:IDX_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/bfc_refill_gather.sv
module bfc_refill_gather #(
    parameter int NUM_TILES = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 collect,
    input  logic [NUM_TILES-1:0] done_in,
    output logic                 all_done
);
    localparam logic [NUM_TILES-1:0] FULL = '1;

    logic [NUM_TILES-1:0] mask_d, mask_q;

    assign all_done = collect && ((mask_q | done_in) == FULL);

    always_comb begin
        mask_d = mask_q;
        if (clear)        mask_d = '0;
        else if (collect) mask_d = mask_q | done_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end
endmodule

// File: rtl/bfc_disp_seq.sv
module bfc_disp_seq #(
    parameter int NUM_TILES = 5,
    parameter int BEATS     = 8,
    parameter int CHUNK_W   = 3,
    localparam int BEAT_W   = $clog2(BEATS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [CHUNK_W-1:0]   start_chunks,
    output logic [NUM_TILES-1:0] en,
    output logic [BEAT_W-1:0]    beat,
    output logic                 last
);
    localparam int MAX_BODY = NUM_TILES - 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    typedef struct packed {
        logic                 active;
        logic [BEAT_W-1:0]    beat;
        logic [NUM_TILES-1:0] mask;
    } seq_t;

    seq_t s_d, s_q;
    int unsigned nbody;
    logic [NUM_TILES-1:0] start_mask;

    always_comb begin
        nbody = int'(start_chunks);
        if (nbody < 1)        nbody = 1;
        if (nbody > MAX_BODY) nbody = MAX_BODY;
        for (int t = 0; t < NUM_TILES; t++) begin
            start_mask[t] = (t <= nbody);
        end
    end

    assign en   = s_q.active ? s_q.mask : '0;
    assign beat = s_q.beat;
    assign last = s_q.active && (s_q.beat == LAST_BEAT);

    always_comb begin
        s_d = s_q;
        if (s_q.active) begin
            if (s_q.beat == LAST_BEAT) begin
                s_d.active = 1'b0;
                s_d.beat   = '0;
                s_d.mask   = '0;
            end else begin
                s_d.beat = s_q.beat + 1'b1;
            end
        end else if (start) begin
            s_d.active = 1'b1;
            s_d.beat   = '0;
            s_d.mask   = start_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/blk_fetch_ctrl.sv
module blk_fetch_ctrl
    import bfc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int IDX_W     = 4,
    parameter int NUM_TILES = 5,
    parameter int BEATS     = 8,
    parameter int CHUNK_W   = 3,
    localparam int BEAT_W   = $clog2(BEATS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [CHUNK_W-1:0]   req_chunks,
    output logic                 busy,
    output logic                 refill_valid,
    output logic [ADDR_W-1:0]    refill_addr,
    input  logic [NUM_TILES-1:0] refill_done,
    output logic [NUM_TILES-1:0] disp_en,
    output logic [BEAT_W-1:0]    disp_beat,
    output logic [ADDR_W-1:0]    disp_addr
);
    typedef struct packed {
        fetch_state_t       state;
        logic [ADDR_W-1:0]  addr;
        logic [CHUNK_W-1:0] chunks;
        logic               pulse;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic                 lk_hit;
    logic                 tag_wr;
    logic                 gather_clear;
    logic                 gather_all;
    logic                 seq_start;
    logic [CHUNK_W-1:0]   seq_chunks;
    logic                 seq_last;

    bfc_tag_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_addr (req_addr),
        .lk_hit  (lk_hit),
        .wr_en   (tag_wr),
        .wr_addr (c_q.addr)
    );

    bfc_refill_gather #(.NUM_TILES(NUM_TILES)) u_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (gather_clear),
        .collect  (c_q.state == ST_REFILL),
        .done_in  (refill_done),
        .all_done (gather_all)
    );

    bfc_disp_seq #(.NUM_TILES(NUM_TILES), .BEATS(BEATS), .CHUNK_W(CHUNK_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (seq_start),
        .start_chunks (seq_chunks),
        .en           (disp_en),
        .beat         (disp_beat),
        .last         (seq_last)
    );

    always_comb begin
        c_d          = c_q;
        c_d.pulse    = 1'b0;
        tag_wr       = 1'b0;
        gather_clear = 1'b0;
        seq_start    = 1'b0;
        seq_chunks   = c_q.chunks;
        unique case (c_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    c_d.addr   = req_addr;
                    c_d.chunks = req_chunks;
                    if (lk_hit) begin
                        seq_start  = 1'b1;
                        seq_chunks = req_chunks;
                        c_d.state  = ST_DISP;
                    end else begin
                        gather_clear = 1'b1;
                        c_d.pulse    = 1'b1;
                        c_d.state    = ST_REFILL;
                    end
                end
            end
            ST_REFILL: begin
                if (gather_all) begin
                    tag_wr    = 1'b1;
                    seq_start = 1'b1;
                    c_d.state = ST_DISP;
                end
            end
            ST_DISP: begin
                if (seq_last) c_d.state = ST_IDLE;
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{state: ST_IDLE, addr: '0, chunks: '0, pulse: 1'b0};
        else        c_q <= c_d;
    end

    assign busy         = (c_q.state != ST_IDLE);
    assign refill_valid = c_q.pulse;
    assign refill_addr  = c_q.addr;
    assign disp_addr    = c_q.addr;
endmodule

// File: rtl/bfc_fetch_chk.sv
module bfc_fetch_chk #(
    parameter int ADDR_W    = 16,
    parameter int NUM_TILES = 5,
    parameter int BEATS     = 8,
    localparam int BEAT_W   = $clog2(BEATS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic                 refill_valid,
    input logic [ADDR_W-1:0]    refill_addr,
    input logic [NUM_TILES-1:0] disp_en,
    input logic [BEAT_W-1:0]    disp_beat
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    // R1: nothing is driven while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (disp_en == '0 && !refill_valid));

    // R3: broadcast lasts one cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        refill_valid |=> !refill_valid);

    // R3: refill address held while busy
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(refill_addr)));

    // R4: no dispatch during the broadcast cycle
    a_r4_no_early_disp: assert property (@(posedge clk) disable iff (!rst_n)
        refill_valid |-> disp_en == '0);

    // R7: header tile always takes part
    a_r7_header_tile: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_en != '0) |-> disp_en[0]);

    // R7: enabled set contiguous from bit 0
    a_r7_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        ((disp_en + NUM_TILES'(1)) & disp_en) == '0);

    // R6: first beat is zero
    a_r6_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_en != '0) |-> disp_beat == '0);

    // R6: beats step by one with stable enables
    a_r6_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_en != '0 && disp_beat != LAST_BEAT) |=>
        (disp_en == $past(disp_en) && disp_beat == BEAT_W'($past(disp_beat) + 1'b1)));

    // R6: dispatch ends after the last beat
    a_r6_end: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_en != '0 && disp_beat == LAST_BEAT) |=> (disp_en == '0 && !busy));
endmodule

bind blk_fetch_ctrl bfc_fetch_chk #(
    .ADDR_W(ADDR_W), .NUM_TILES(NUM_TILES), .BEATS(BEATS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .refill_valid (refill_valid),
    .refill_addr  (refill_addr),
    .disp_en      (disp_en),
    .disp_beat    (disp_beat)
);

// File: tb/sim_blk_fetch_ctrl.sv
module sim_blk_fetch_ctrl;
    localparam int ADDR_W = 16;
    localparam int NT     = 5;
    localparam int BEATS  = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [15:0]     req_addr = '0;
    logic [2:0]      req_chunks = '0;
    logic            busy, refill_valid;
    logic [15:0]     refill_addr, disp_addr;
    logic [NT-1:0]   refill_done = '0;
    logic [NT-1:0]   disp_en;
    logic [2:0]      disp_beat;

    always #5 clk = ~clk;

    blk_fetch_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_chunks(req_chunks), .busy(busy), .refill_valid(refill_valid),
        .refill_addr(refill_addr), .refill_done(refill_done), .disp_en(disp_en),
        .disp_beat(disp_beat), .disp_addr(disp_addr)
    );

    typedef struct { logic [15:0] addr; logic [NT-1:0] mask; } exp_t;
    exp_t exp_q[$];
    int checks = 0;
    int fails  = 0;
    int run    = 0;
    exp_t cur;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    function automatic logic [NT-1:0] mask_of(input int ch);
        int n = ch;
        if (n < 1) n = 1;
        if (n > NT - 1) n = NT - 1;
        return NT'((1 << (n + 1)) - 1);
    endfunction

    // monitor: scoreboard for dispatch runs (R6, R7)
    always @(negedge clk) begin
        if (rst_n) begin
            if (disp_en != '0) begin
                if (run == 0) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R8 unexpected dispatch", int'(disp_addr), 0);
                        cur.addr = disp_addr; cur.mask = disp_en;
                    end else begin
                        cur = exp_q.pop_front();
                        chk(disp_addr == cur.addr, "R6 dispatch address", int'(disp_addr), int'(cur.addr));
                        chk(disp_en == cur.mask, "R7 tile enables", int'(disp_en), int'(cur.mask));
                    end
                end
                chk(int'(disp_beat) == run && disp_en == cur.mask, "R6 beat sequence", int'(disp_beat), run);
                run++;
            end else if (run != 0) begin
                chk(run == BEATS && !busy, "R6 dispatch length", run, BEATS);
                run = 0;
            end
        end
    end

    task automatic issue(input logic [15:0] a, input int ch, input bit hit);
        exp_t e;
        while (busy) @(negedge clk);
        e.addr = a; e.mask = mask_of(ch);
        exp_q.push_back(e);
        req_valid = 1'b1; req_addr = a; req_chunks = 3'(ch);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy, "R2 accepted", int'(busy), 1);
        if (hit) begin
            chk(!refill_valid, "R2 hit gives no broadcast", int'(refill_valid), 0);
            chk(disp_en != '0, "R2 hit dispatches next cycle", int'(disp_en), int'(e.mask));
        end else begin
            chk(refill_valid && refill_addr == a, "R3 miss broadcast", int'(refill_addr), int'(a));
            chk(disp_en == '0, "R4 no dispatch at broadcast", int'(disp_en), 0);
        end
    endtask

    task automatic give_done(input logic [NT-1:0] bits, input bit final_one);
        refill_done = bits;
        @(negedge clk);
        refill_done = '0;
        if (!final_one) begin
            chk(disp_en == '0 && busy && !refill_valid, "R4 held until all tiles", int'(disp_en), 0);
        end else begin
            chk(disp_en != '0, "R5 dispatch after last done", int'(disp_en), 1);
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && disp_en == '0 && !refill_valid, "R1 reset state", int'(busy), 0);

        // R1 first access misses; R4 partial, duplicate and grouped done bits
        issue(16'h0013, 2, 0);
        give_done(5'b00001, 0);
        give_done(5'b00010, 0);
        give_done(5'b00010, 0);
        give_done(5'b10100, 0);
        give_done(5'b01000, 1);
        wait_idle();

        // R5 installed line hits, R7 full body
        issue(16'h0013, 4, 1);
        wait_idle();

        // R9 same index, different tag misses; R4 all bits at once; R7 clamp 0 -> 1
        issue(16'h0023, 0, 0);
        give_done(5'b11111, 1);
        wait_idle();

        // R9 replaced line now misses; R8 request while busy ignored
        issue(16'h0013, 1, 0);
        req_valid = 1'b1; req_addr = 16'h0045; req_chunks = 3'd3;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!refill_valid && disp_en == '0, "R8 busy request ignored", int'(refill_valid), 0);
        give_done(5'b11111, 1);
        wait_idle();
        chk(exp_q.size() == 0, "R8 no extra dispatch", exp_q.size(), 0);

        // R8 ignored request left nothing installed; R7 clamp 7 -> 4
        issue(16'h0045, 7, 0);
        give_done(5'b11111, 1);
        wait_idle();
        issue(16'h0045, 1, 1);
        wait_idle();

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0 && !busy, "R6 all dispatches seen", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule